// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM and takes the memory from reset to a state where ordinary traffic may begin. Once reset is released it holds the clock enable and the data mask high and sends no-op commands for a stabilization time. It then closes every bank with a precharge-all and, after the precharge time, sends a run of auto refresh commands spaced by the refresh cycle time. Last, it loads the mode register with a word built from parameters and waits out the mode-register-to-activate interval before it raises `init_done`.

Every delay is given in nanoseconds and converted to clock cycles at elaboration. The conversion rounds up against the clock period parameter. The mode word is fixed at elaboration: CAS latency, burst type, burst length and write mode. A configuration that asks for a reserved code stops elaboration. A controller that shares the command pins must not drive them until `init_done` is high.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and until `init_done` rises, `cke` and `dqm` are 1. The pins carry only four commands: NOP (cs_n,ras_n,cas_n,we_n = 0111), precharge-all (0010), auto refresh (0001) and mode set (0000). Every cycle that is not a sequence command is NOP.
- R2: Precharge-all appears on the STABLE_CYC-th rising edge after `rst_n` is released, with `ba` = 0 and only address bit 10 set.
- R3: The first auto refresh, with `ba` = 0 and `addr` = 0, appears exactly RP_CYC edges after precharge-all.
- R4: Exactly REF_COUNT auto refreshes are issued, and each one is exactly RFC_CYC edges after the previous one.
- R5: Mode set appears exactly RFC_CYC edges after the last refresh, with `ba` = 0 and the address fields as follows:
  - addr[11:10] = 00 and addr[8:7] = 00
  - addr[9] = SINGLE_WRITE (1 = single write, 0 = burst write)
  - addr[6:4] = latency code
  - addr[3] = BURST_INTERLEAVE (1 = interleave, 0 = sequential)
  - addr[2:0] = length code
- R6: Latency codes: 2 gives 010 and 3 gives 011. Length codes: 1 gives 000, 2 gives 001, 4 gives 010, 8 gives 011, and 0 (full page) gives 111.
- R7: `init_done` rises exactly MRD_CYC edges after mode set and stays high until reset. While it is high the pins carry NOP and `dqm` is 0.
- R8: Each wait in cycles is X_CYC = ceil(T_X_NS * 1000 / CLK_PERIOD_PS), with a minimum of 1.
- R9: Elaboration is rejected for any of these reserved configurations:
  - a latency other than 2 or 3
  - a length other than 0, 1, 2, 4 or 8
  - full page with interleave
  - REF_COUNT below 8

  `sdram_init_pkg::mode_fields_legal` returns 0 for the reserved mode-field combinations.
- R10: A reset asserted at any point drops the rest of the sequence. The block restarts from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory, held high |
| dqm | output | 1 | Data mask, high until init_done |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Row/mode address bus |
| init_done | output | 1 | High once ordinary commands may begin |

## Verification
The assertions assume that the only input besides the clock is the reset. They also assume the reset is applied and released away from the active clock edge, so that the gap counter in the checker always starts from a cleanly reset state. The bench changes `rst_n` two nanoseconds after a rising edge and holds it across several edges. It includes a reset in the middle of the refresh run, and the assertions must hold across that restart as well. Three instances with distinct legal timing and mode parameters supply the distinct patterns, because no other input exists.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
package sdram_init_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_REF  = 2'd2,
        CMD_MRS  = 2'd3
    } cmd_e;

    typedef enum logic [2:0] {
        ST_STABLE = 3'd0,
        ST_RP     = 3'd1,
        ST_RFC    = 3'd2,
        ST_MRD    = 3'd3,
        ST_DONE   = 3'd4
    } state_e;

    localparam int unsigned MODE_W = 12;

    // Nanoseconds to cycles, rounded up, never below one cycle (R8).
    function automatic int unsigned wait_cycles(input longint unsigned t_ns,
                                                input int unsigned period_ps);
        longint unsigned c;
        c = (t_ns * 64'd1000 + 64'(period_ps) - 64'd1) / 64'(period_ps);
        if (c == 64'd0) c = 64'd1;
        return 32'(c);
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Latency code of the mode word (R6).
    function automatic logic [2:0] latency_code(input int unsigned cl);
        case (cl)
            2:       return 3'b010;
            3:       return 3'b011;
            default: return 3'b000;
        endcase
    endfunction

    // Length code of the mode word; 0 means a whole row (R6).
    function automatic logic [2:0] length_code(input int unsigned bl);
        case (bl)
            0:       return 3'b111;
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b100;
        endcase
    endfunction

    // Legality of the mode fields (R9).
    function automatic bit mode_fields_legal(input int unsigned cl,
                                             input int unsigned bl,
                                             input bit interleave);
        bit ok;
        ok = (cl == 2) || (cl == 3);
        ok = ok && ((bl == 0) || (bl == 1) || (bl == 2) || (bl == 4) || (bl == 8));
        ok = ok && !((bl == 0) && interleave);
        return ok;
    endfunction

    // Mode word layout (R5).
    function automatic logic [MODE_W-1:0] mode_word(input int unsigned cl,
                                                    input int unsigned bl,
                                                    input bit interleave,
                                                    input bit single_write);
        logic [MODE_W-1:0] w;
        w       = '0;
        w[9]    = single_write;
        w[6:4]  = latency_code(cl);
        w[3]    = interleave;
        w[2:0]  = length_code(bl);
        return w;
    endfunction

endpackage

// File: rtl/sdram_init_modeword.sv
`timescale 1ns/1ps
module sdram_init_modeword
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W           = 12,
    parameter int unsigned CAS_LATENCY      = 3,
    parameter int unsigned BURST_LEN        = 8,
    parameter int unsigned BURST_INTERLEAVE = 0,
    parameter int unsigned SINGLE_WRITE     = 0,
    parameter int unsigned REF_COUNT        = 8
) (
    output logic [ADDR_W-1:0] mode_addr
);

    localparam bit IL_BIT = (BURST_INTERLEAVE != 0);
    localparam bit SW_BIT = (SINGLE_WRITE != 0);
    localparam logic [MODE_W-1:0] WORD = mode_word(CAS_LATENCY, BURST_LEN, IL_BIT, SW_BIT);

    // Elaboration-time rejection of reserved configurations (R9).
    if (!mode_fields_legal(CAS_LATENCY, BURST_LEN, IL_BIT)) begin : g_bad_mode
        $error("sdram_init_modeword: reserved latency/length/type combination");
    end
    if (REF_COUNT < 8) begin : g_bad_refs
        $error("sdram_init_modeword: refresh count must be at least 8");
    end
    if (ADDR_W < MODE_W) begin : g_bad_addr
        $error("sdram_init_modeword: address bus narrower than the mode word");
    end

    assign mode_addr = ADDR_W'(WORD);

endmodule

// File: rtl/sdram_init_delay.sv
`timescale 1ns/1ps
module sdram_init_delay #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(RESET_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_pins.sv
`timescale 1ns/1ps
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned BA_W   = 2
) (
    input  cmd_e              cmd,
    input  logic [ADDR_W-1:0] mode_addr,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PALL: begin
                ras_n    = 1'b0;
                we_n     = 1'b0;
                addr[10] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = mode_addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W           = 12,
    parameter int unsigned BA_W             = 2,
    parameter int unsigned CLK_PERIOD_PS    = 8000,
    parameter int unsigned T_STABLE_NS      = 200000,
    parameter int unsigned T_RP_NS          = 20,
    parameter int unsigned T_RFC_NS         = 70,
    parameter int unsigned T_MRD_NS         = 14,
    parameter int unsigned REF_COUNT        = 8,
    parameter int unsigned CAS_LATENCY      = 3,
    parameter int unsigned BURST_LEN        = 8,
    parameter int unsigned BURST_INTERLEAVE = 0,
    parameter int unsigned SINGLE_WRITE     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              dqm,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned STABLE_CYC = wait_cycles(T_STABLE_NS, CLK_PERIOD_PS);
    localparam int unsigned RP_CYC     = wait_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC    = wait_cycles(T_RFC_NS, CLK_PERIOD_PS);
    localparam int unsigned MRD_CYC    = wait_cycles(T_MRD_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_WAIT   = umax(umax(STABLE_CYC, RP_CYC), umax(RFC_CYC, MRD_CYC));
    localparam int unsigned CNT_W      = $clog2(MAX_WAIT + 1);
    localparam int unsigned REF_W      = $clog2(REF_COUNT + 1);

    typedef struct packed {
        state_e           st;
        cmd_e             cmd;
        logic [REF_W-1:0] refs;
        logic             done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             wait_load;
    logic [CNT_W-1:0] wait_val;
    logic             wait_over;
    logic [ADDR_W-1:0] mode_addr;

    sdram_init_modeword #(
        .ADDR_W          (ADDR_W),
        .CAS_LATENCY     (CAS_LATENCY),
        .BURST_LEN       (BURST_LEN),
        .BURST_INTERLEAVE(BURST_INTERLEAVE),
        .SINGLE_WRITE    (SINGLE_WRITE),
        .REF_COUNT       (REF_COUNT)
    ) u_modeword (
        .mode_addr(mode_addr)
    );

    // One shared down-counter times every wait; its reset value is the
    // stabilization wait so no extra state is needed at reset (R2, R10).
    sdram_init_delay #(
        .CNT_W    (CNT_W),
        .RESET_VAL(STABLE_CYC - 1)
    ) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (wait_load),
        .load_val(wait_val),
        .expired (wait_over)
    );

    // Next-state logic: a command is launched in the cycle its wait expires,
    // and the counter is reloaded with the wait that follows that command.
    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cmd = CMD_NOP;
        wait_load = 1'b0;
        wait_val  = '0;
        if (wait_over) begin
            unique case (ctl_q.st)
                ST_STABLE: begin
                    ctl_d.cmd = CMD_PALL;
                    ctl_d.st  = ST_RP;
                    wait_load = 1'b1;
                    wait_val  = CNT_W'(RP_CYC - 1);
                end
                ST_RP: begin
                    ctl_d.cmd  = CMD_REF;
                    ctl_d.refs = REF_W'(REF_COUNT - 1);
                    ctl_d.st   = ST_RFC;
                    wait_load  = 1'b1;
                    wait_val   = CNT_W'(RFC_CYC - 1);
                end
                ST_RFC: begin
                    wait_load = 1'b1;
                    if (ctl_q.refs != '0) begin
                        ctl_d.cmd  = CMD_REF;
                        ctl_d.refs = ctl_q.refs - 1'b1;
                        wait_val   = CNT_W'(RFC_CYC - 1);
                    end else begin
                        ctl_d.cmd = CMD_MRS;
                        ctl_d.st  = ST_MRD;
                        wait_val  = CNT_W'(MRD_CYC - 1);
                    end
                end
                ST_MRD: begin
                    ctl_d.done = 1'b1;
                    ctl_d.st   = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_STABLE, cmd: CMD_NOP, refs: '0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sdram_init_pins #(
        .ADDR_W(ADDR_W),
        .BA_W  (BA_W)
    ) u_pins (
        .cmd      (ctl_q.cmd),
        .mode_addr(mode_addr),
        .cs_n     (cs_n),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .ba       (ba),
        .addr     (addr)
    );

    assign cke       = 1'b1;
    assign dqm       = ~ctl_q.done;
    assign init_done = ctl_q.done;

endmodule

// File: rtl/sdram_init_checks.sv
`timescale 1ns/1ps
module sdram_init_checks
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned T_RP_NS       = 20,
    parameter int unsigned T_RFC_NS      = 70,
    parameter int unsigned T_MRD_NS      = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              dqm,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    localparam int unsigned RP_CYC  = wait_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned RFC_CYC = wait_cycles(T_RFC_NS, CLK_PERIOD_PS);
    localparam int unsigned MRD_CYC = wait_cycles(T_MRD_NS, CLK_PERIOD_PS);

    logic is_nop, is_pall, is_ref, is_mrs;
    assign is_nop  = !cs_n &&  ras_n &&  cas_n &&  we_n;
    assign is_pall = !cs_n && !ras_n &&  cas_n && !we_n;
    assign is_ref  = !cs_n && !ras_n && !cas_n &&  we_n;
    assign is_mrs  = !cs_n && !ras_n && !cas_n && !we_n;

    // Last command seen on the pins and edges since it appeared.
    cmd_e        last_q;
    logic [31:0] gap_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= CMD_NOP;
            gap_q  <= '0;
        end else if (!is_nop) begin
            last_q <= is_pall ? CMD_PALL : (is_ref ? CMD_REF : CMD_MRS);
            gap_q  <= 32'd1;
        end else if (gap_q != '1) begin
            gap_q  <= gap_q + 32'd1;
        end
    end

    p_cke_high_r1: assert property (@(posedge clk) disable iff (!rst_n) cke);
    p_dqm_hold_r1: assert property (@(posedge clk) disable iff (!rst_n) !init_done |-> dqm);
    p_legal_cmds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        is_nop || is_pall || is_ref || is_mrs);
    p_pall_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        is_pall |-> (ba == '0) && (addr == (ADDR_W'(1) << 10)));
    p_first_ref_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && last_q == CMD_PALL) |-> gap_q == RP_CYC);
    p_ref_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && last_q == CMD_REF) |-> gap_q == RFC_CYC);
    p_mrs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (last_q == CMD_REF) && (gap_q == RFC_CYC));
    p_mrs_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (ba == '0) && (addr[11:10] == 2'b00) && (addr[8:7] == 2'b00));
    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (last_q == CMD_MRS) && (gap_q == MRD_CYC));
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop && !dqm);

endmodule

bind sdram_init_seq sdram_init_checks #(
    .ADDR_W       (ADDR_W),
    .BA_W         (BA_W),
    .CLK_PERIOD_PS(CLK_PERIOD_PS),
    .T_RP_NS      (T_RP_NS),
    .T_RFC_NS     (T_RFC_NS),
    .T_MRD_NS     (T_MRD_NS)
) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .cke      (cke),
    .dqm      (dqm),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .addr     (addr),
    .init_done(init_done)
);

// File: tb/sdram_init_seq_bench.sv
`timescale 1ns/1ps
module sdram_init_seq_bench;
    import sdram_init_pkg::*;

    localparam int unsigned PERIOD_PS = 8000;

    typedef struct {
        logic [3:0]  pins;
        logic [1:0]  ba;
        logic [11:0] addr;
        int unsigned at;
        string       tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int unsigned checks = 0;
    int unsigned fails  = 0;
    int unsigned edges  = 0;
    bit          finished = 1'b0;

    item_t q0[$];
    item_t q1[$];
    item_t q2[$];

    logic        cke_w [3];
    logic        dqm_w [3];
    logic        cs_w  [3];
    logic        ras_w [3];
    logic        cas_w [3];
    logic        we_w  [3];
    logic [1:0]  ba_w  [3];
    logic [11:0] addr_w[3];
    logic        done_w[3];
    logic        done_prev[3];

    always @(posedge clk) begin
        if (rst_n) edges <= edges + 1;
        else       edges <= 0;
    end

    // Default configuration: CL3, length 8, sequential, burst write.
    sdram_init_seq u_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .cke(cke_w[0]), .dqm(dqm_w[0]),
        .cs_n(cs_w[0]), .ras_n(ras_w[0]), .cas_n(cas_w[0]), .we_n(we_w[0]),
        .ba(ba_w[0]), .addr(addr_w[0]), .init_done(done_w[0]));

    // CL2, length 4, interleave, single write, nine refreshes.
    sdram_init_seq #(
        .T_STABLE_NS(1000), .T_RP_NS(8), .T_RFC_NS(60), .T_MRD_NS(0),
        .REF_COUNT(9), .CAS_LATENCY(2), .BURST_LEN(4),
        .BURST_INTERLEAVE(1), .SINGLE_WRITE(1)
    ) u_alt (
        .clk(clk), .rst_n(rst_n), .cke(cke_w[1]), .dqm(dqm_w[1]),
        .cs_n(cs_w[1]), .ras_n(ras_w[1]), .cas_n(cas_w[1]), .we_n(we_w[1]),
        .ba(ba_w[1]), .addr(addr_w[1]), .init_done(done_w[1]));

    // CL3, full page, sequential, burst write.
    sdram_init_seq #(
        .T_STABLE_NS(500), .T_RP_NS(24), .T_RFC_NS(80), .T_MRD_NS(16),
        .REF_COUNT(8), .CAS_LATENCY(3), .BURST_LEN(0),
        .BURST_INTERLEAVE(0), .SINGLE_WRITE(0)
    ) u_fp (
        .clk(clk), .rst_n(rst_n), .cke(cke_w[2]), .dqm(dqm_w[2]),
        .cs_n(cs_w[2]), .ras_n(ras_w[2]), .cas_n(cas_w[2]), .we_n(we_w[2]),
        .ba(ba_w[2]), .addr(addr_w[2]), .init_done(done_w[2]));

    // R8: ceil(ns*1000/period), at least one cycle.
    function automatic int unsigned cyc(input int unsigned ns);
        int unsigned c;
        c = (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
        return (c == 0) ? 1 : c;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_item(input int i, input item_t it);
        case (i)
            0:       q0.push_back(it);
            1:       q1.push_back(it);
            default: q2.push_back(it);
        endcase
    endtask

    // Driver: queue the commands expected from one instance.
    task automatic push_seq(input int i, input int unsigned s, input int unsigned rp,
                            input int unsigned rfc, input int unsigned mrd,
                            input int unsigned n, input logic [11:0] mode);
        item_t it;
        it = '{pins: 4'b0010, ba: 2'd0, addr: 12'h400, at: s, tag: "R2"};
        push_item(i, it);
        for (int k = 0; k < n; k++) begin
            it = '{pins: 4'b0001, ba: 2'd0, addr: 12'h000, at: s + rp + k * rfc,
                   tag: (k == 0) ? "R3 R8" : "R4"};
            push_item(i, it);
        end
        it = '{pins: 4'b0000, ba: 2'd0, addr: mode, at: s + rp + n * rfc, tag: "R5 R6"};
        push_item(i, it);
        it = '{pins: 4'b1111, ba: 2'd0, addr: 12'h000, at: s + rp + n * rfc + mrd, tag: "R7"};
        push_item(i, it);
    endtask

    task automatic push_all();
        // Mode words: 0x033 = CL3 seq len8; 0x22A = single write CL2 interleave len4;
        // 0x037 = CL3 seq full page.
        push_seq(0, cyc(200000), cyc(20), cyc(70), cyc(14), 8, 12'h033);
        push_seq(1, cyc(1000),   cyc(8),  cyc(60), cyc(0),  9, 12'h22A);
        push_seq(2, cyc(500),    cyc(24), cyc(80), cyc(16), 8, 12'h037);
    endtask

    // Monitor side: pop and compare one observed event.
    task automatic observe(input int i, input logic [3:0] pins,
                           input logic [1:0] ba, input logic [11:0] addr);
        item_t e;
        bit    have;
        have = 1'b1;
        case (i)
            0:       if (q0.size() != 0) e = q0.pop_front(); else have = 1'b0;
            1:       if (q1.size() != 0) e = q1.pop_front(); else have = 1'b0;
            default: if (q2.size() != 0) e = q2.pop_front(); else have = 1'b0;
        endcase
        checks++;
        if (!have) begin
            fails++;
            $display("FAIL R7 inst %0d unexpected event: actual pins=%b addr=%h edge=%0d expected none",
                     i, pins, addr, edges);
        end else if (pins != e.pins || ba != e.ba || addr != e.addr || edges != e.at) begin
            fails++;
            $display("FAIL %s inst %0d: actual pins=%b ba=%0d addr=%h edge=%0d expected pins=%b ba=%0d addr=%h edge=%0d",
                     e.tag, i, pins, ba, addr, edges, e.pins, e.ba, e.addr, e.at);
        end
    endtask

    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            logic [3:0] pins;
            pins = {cs_w[i], ras_w[i], cas_w[i], we_w[i]};
            if (!rst_n) begin
                // R1 R10: reset state
                check(pins == 4'b0111 && cke_w[i] && dqm_w[i] && !done_w[i], "R1 R10",
                      "pins/cke/dqm/done during reset",
                      {27'd0, pins, done_w[i]}, {27'd0, 4'b0111, 1'b0});
                done_prev[i] = 1'b0;
            end else begin
                check(cke_w[i] == 1'b1 && dqm_w[i] == !done_w[i], "R1 R7",
                      "cke/dqm level", {30'd0, cke_w[i], dqm_w[i]}, {30'd0, 1'b1, !done_w[i]});
                if (done_prev[i] && !done_w[i])
                    check(1'b0, "R7", "init_done fell", 32'd0, 32'd1);
                if (pins != 4'b0111)
                    observe(i, pins, ba_w[i], addr_w[i]);
                if (done_w[i] && !done_prev[i])
                    observe(i, 4'b1111, 2'd0, 12'h000);
                done_prev[i] = done_w[i];
            end
        end
    end

    task automatic step(input int unsigned n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) done_prev[i] = 1'b0;

        // R6 R9: code values and legality from the package
        check(length_code(1) == 3'b000, "R6", "length code for 1", 32'(length_code(1)), 32'h0);
        check(length_code(2) == 3'b001, "R6", "length code for 2", 32'(length_code(2)), 32'h1);
        check(latency_code(2) == 3'b010, "R6", "latency code for 2", 32'(latency_code(2)), 32'h2);
        check(mode_fields_legal(1, 8, 1'b0) == 1'b0, "R9", "latency 1 legal",
              32'(mode_fields_legal(1, 8, 1'b0)), 32'd0);
        check(mode_fields_legal(3, 0, 1'b1) == 1'b0, "R9", "full page interleave legal",
              32'(mode_fields_legal(3, 0, 1'b1)), 32'd0);
        check(mode_fields_legal(3, 16, 1'b0) == 1'b0, "R9", "length 16 legal",
              32'(mode_fields_legal(3, 16, 1'b0)), 32'd0);
        check(mode_fields_legal(2, 4, 1'b1) == 1'b1, "R9", "CL2 len4 interleave legal",
              32'(mode_fields_legal(2, 4, 1'b1)), 32'd1);

        step(3);
        push_all();
        rst_n = 1'b1;

        // Interrupt during the refresh run (R10).
        step(140);
        check(q1.size() == 9, "R10", "u_alt events left before mid reset", q1.size(), 9);
        check(q2.size() == 2, "R10", "u_fp events left before mid reset", q2.size(), 2);
        check(q0.size() == 11, "R10", "default events left before mid reset", q0.size(), 11);
        rst_n = 1'b0;
        q0.delete();
        q1.delete();
        q2.delete();
        step(5);
        push_all();
        rst_n = 1'b1;

        step(25100);
        check(q0.size() == 0 && q1.size() == 0 && q2.size() == 0, "R7",
              "events outstanding at end", q0.size() + q1.size() + q2.size(), 0);
        check(done_w[0] && done_w[1] && done_w[2], "R7", "init_done at end",
              {29'd0, done_w[0], done_w[1], done_w[2]}, 32'h7);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule